// File: doc/BRIEF.md
# Window Growth Arbiter for Event Clustering

This block decides whether a rectangular clustering window may grow by one step to take in a newly detected event. A clustering engine hands it up to four candidate windows. Each candidate comes with the direction in which it must grow to reach the event. The engine then streams in the nearby windows that could collide with that growth. The arbiter keeps a legality flag per candidate and per direction, clearing flags as near windows arrive. When the last group has arrived it applies the size limit, the processing-region limit and a fixed direction priority. It returns either the chosen candidate with its grown rectangle, or a request to open a fresh 1×1 window at the event.

A window is (x, y, w, h): x and y give the top-left pixel, and w and h are the width and height in pixels. Near windows arrive over `LAT` beats of `ceil(NEAR_MAX/LAT)` slots each. This lets the integrator trade cycles per event against comparator count. Storing windows and choosing which windows count as near is left to the surrounding engine.

Top module: `win_grow_arbiter`

## Requirements
- R1: After reset, `res_valid` is low and stays low until an event has been started and fed.
- R2: After `ev_start`, the result appears with `res_valid` high in the cycle after the `LAT`-th `nb_beat` cycle. `res_valid` is a one-cycle pulse. When `ev_start` and `nb_beat` are both high, `ev_start` wins.
- R3: A candidate with direction INSIDE reports success with its window unchanged, whatever near windows are fed.
- R4: Right growth (result w+1) is blocked by a near window unless gapR≥1, gapL≥0, gapU≥0 or gapD≥0. The gaps are gapL = cx−(nx+nw), gapR = nx−(cx+cw), gapU = cy−(ny+nh) and gapD = ny−(cy+ch), all signed.
- R5: Right-down growth (w+1, h+1) is blocked unless gapR≥1, gapL≥0, gapU≥0 or gapD≥1.
- R6: Down growth (h+1) is blocked unless gapR≥0, gapL≥0, gapU≥0 or gapD≥1.
- R7: Left-down growth (x−1, w+1, h+1) is blocked unless gapR≥0, gapL≥1, gapU≥0 or gapD≥1.
- R8: A growth is legal only if no near window blocks it, across all slots of all beats of the event. A slot whose `nb_vld` bit is low has no effect.
- R9: A growth that would make w or h exceed `MAX_SIZE` (8) is illegal.
- R10: A growth is illegal if the grown window would leave the region. The region covers x from 0 to `REGION_W`−1 (584) and y from 0 to `REGION_H`−1 (499), so left-down growth needs x≥1.
- R11: The choice order is INSIDE first, then R, RD, D and LD. Among candidates of equal rank, the lowest index wins.
- R12: If no candidate is INSIDE or legally growable, `res_new` is high and the output window is (ev_x, ev_y, 1, 1). Exactly one of `res_hit` and `res_new` is high with each result.
- R13: Direction codes are 0 none, 1 INSIDE, 2 R, 3 RD, 4 D, 5 LD. Codes 0, 6 and 7 mark an absent candidate, which is never chosen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ev_start | input | 1 | Latch a new event and its candidates |
| ev_x | input | COORD_W | Event column |
| ev_y | input | COORD_W | Event row |
| cand_dir | input | N_CAND×3 | Required growth direction per candidate |
| cand_x | input | N_CAND×COORD_W | Candidate left column |
| cand_y | input | N_CAND×COORD_W | Candidate top row |
| cand_w | input | N_CAND×DIM_W | Candidate width |
| cand_h | input | N_CAND×DIM_W | Candidate height |
| nb_beat | input | 1 | A group of near windows is present |
| nb_vld | input | GRP | Slot valid mask |
| nb_x | input | GRP×COORD_W | Near window left column |
| nb_y | input | GRP×COORD_W | Near window top row |
| nb_w | input | GRP×DIM_W | Near window width |
| nb_h | input | GRP×DIM_W | Near window height |
| res_valid | output | 1 | Result pulse |
| res_hit | output | 1 | A candidate was chosen |
| res_new | output | 1 | Open a new 1×1 window |
| res_idx | output | IDX_W | Chosen candidate index |
| res_x | output | COORD_W | Result window column |
| res_y | output | COORD_W | Result window row |
| res_w | output | DIM_W | Result window width |
| res_h | output | DIM_W | Result window height |

## Verification
The hardest case to reach is a candidate that is blocked only by a near window arriving in a later beat. A blocker in the first beat, or a single beat, would not separate a design that keeps every beat's flags from one that only keeps the latest group. The stimulus places a harmless near window in the first beat and the blocker in the last slot of the second beat. It also repeats a blocker with its valid bit cleared. A second hard case is the priority between candidates that are legal at the same time. Directed events give several candidates different or equal ranks, with blockers chosen so that only the intended subset stays legal.

// File: rtl/wgrow_pkg.sv
package wgrow_pkg;
  typedef enum logic [2:0] {
    DIR_NONE = 3'd0,
    DIR_IN   = 3'd1,
    DIR_R    = 3'd2,
    DIR_RD   = 3'd3,
    DIR_D    = 3'd4,
    DIR_LD   = 3'd5
  } grow_dir_e;

  // flag bit positions inside a 4-bit legality vector
  localparam int BIT_R  = 0;
  localparam int BIT_RD = 1;
  localparam int BIT_D  = 2;
  localparam int BIT_LD = 3;
  localparam int NDIR   = 4;

  // selection keys: 0 inside, 1..4 growth rank, KEY_NONE not eligible
  localparam logic [2:0] KEY_IN   = 3'd0;
  localparam logic [2:0] KEY_NONE = 3'd7;

  function automatic logic [1:0] dir_rank(input logic [2:0] d);
    logic [2:0] t;
    t = d - 3'd2;
    return t[1:0];
  endfunction
endpackage

// File: rtl/wgrow_near_cmp.sv
module wgrow_near_cmp #(
  parameter int COORD_W = 11,
  parameter int DIM_W   = 4
) (
  input  logic [COORD_W-1:0] cx,
  input  logic [COORD_W-1:0] cy,
  input  logic [DIM_W-1:0]   cw,
  input  logic [DIM_W-1:0]   ch,
  input  logic [COORD_W-1:0] nx,
  input  logic [COORD_W-1:0] ny,
  input  logic [DIM_W-1:0]   nw,
  input  logic [DIM_W-1:0]   nh,
  output logic [3:0]         ok
);
  import wgrow_pkg::*;
  localparam int GW = COORD_W + 1;

  // signed distance from the far edge of (b, bsz) to a
  function automatic logic signed [GW-1:0] gap(input logic [COORD_W-1:0] a,
                                               input logic [COORD_W-1:0] b,
                                               input logic [DIM_W-1:0] bsz);
    return $signed({1'b0, a}) - $signed({1'b0, b}) - $signed(GW'(bsz));
  endfunction

  function automatic logic ge0(input logic signed [GW-1:0] d);
    return !d[GW-1];
  endfunction

  function automatic logic ge1(input logic signed [GW-1:0] d);
    return !d[GW-1] && (d != '0);
  endfunction

  logic signed [GW-1:0] gap_l, gap_r, gap_u, gap_d;
  logic free_r, free_rd, free_d, free_ld;

  assign gap_l = gap(cx, nx, nw);
  assign gap_r = gap(nx, cx, cw);
  assign gap_u = gap(cy, ny, nh);
  assign gap_d = gap(ny, cy, ch);

  assign free_r  = ge1(gap_r) || ge0(gap_l) || ge0(gap_u) || ge0(gap_d);
  assign free_rd = ge1(gap_r) || ge0(gap_l) || ge0(gap_u) || ge1(gap_d);
  assign free_d  = ge0(gap_r) || ge0(gap_l) || ge0(gap_u) || ge1(gap_d);
  assign free_ld = ge0(gap_r) || ge1(gap_l) || ge0(gap_u) || ge1(gap_d);

  always_comb begin
    ok         = '0;
    ok[BIT_R]  = free_r;
    ok[BIT_RD] = free_rd;
    ok[BIT_D]  = free_d;
    ok[BIT_LD] = free_ld;
  end

  // R5: a clear right-down path implies clear right and down paths
  always_comb begin
    if (!$isunknown(ok)) begin
      a_r5_rd_implies: assert (!ok[BIT_RD] || (ok[BIT_R] && ok[BIT_D]));
      a_r7_ld_implies: assert (!ok[BIT_LD] || ok[BIT_D]);
    end
  end
endmodule

// File: rtl/wgrow_cand_eval.sv
module wgrow_cand_eval #(
  parameter int COORD_W  = 11,
  parameter int DIM_W    = 4,
  parameter int MAX_SIZE = 8,
  parameter int REGION_W = 585,
  parameter int REGION_H = 500
) (
  input  logic [2:0]         dir,
  input  logic [COORD_W-1:0] x,
  input  logic [COORD_W-1:0] y,
  input  logic [DIM_W-1:0]   w,
  input  logic [DIM_W-1:0]   h,
  input  logic [3:0]         near_ok,
  output logic [2:0]         key,
  output logic [COORD_W-1:0] gx,
  output logic [COORD_W-1:0] gy,
  output logic [DIM_W-1:0]   gw,
  output logic [DIM_W-1:0]   gh
);
  import wgrow_pkg::*;

  logic room_w, room_h, fit_r, fit_d, fit_l;
  logic size_ok, bound_ok, is_grow, legal;
  logic [1:0] rank;

  assign room_w = int'(w) < MAX_SIZE;
  assign room_h = int'(h) < MAX_SIZE;
  assign fit_r  = (int'(x) + int'(w)) < REGION_W;
  assign fit_d  = (int'(y) + int'(h)) < REGION_H;
  assign fit_l  = (x != '0);
  assign rank   = dir_rank(dir);

  always_comb begin
    is_grow  = 1'b1;
    size_ok  = 1'b0;
    bound_ok = 1'b0;
    gx = x;
    gy = y;
    gw = w;
    gh = h;
    case (dir)
      DIR_R: begin
        size_ok = room_w;
        bound_ok = fit_r;
        gw = w + DIM_W'(1);
      end
      DIR_RD: begin
        size_ok = room_w && room_h;
        bound_ok = fit_r && fit_d;
        gw = w + DIM_W'(1);
        gh = h + DIM_W'(1);
      end
      DIR_D: begin
        size_ok = room_h;
        bound_ok = fit_d;
        gh = h + DIM_W'(1);
      end
      DIR_LD: begin
        size_ok = room_w && room_h;
        bound_ok = fit_l && fit_d;
        gx = x - COORD_W'(1);
        gw = w + DIM_W'(1);
        gh = h + DIM_W'(1);
      end
      default: is_grow = 1'b0;
    endcase
  end

  assign legal = is_grow && size_ok && bound_ok && near_ok[rank];

  always_comb begin
    if (dir == DIR_IN) key = KEY_IN;
    else if (legal)    key = 3'(rank) + 3'd1;
    else               key = KEY_NONE;
  end
endmodule

// File: rtl/wgrow_pick.sv
module wgrow_pick #(
  parameter int N_CAND = 4,
  localparam int IDX_W = (N_CAND > 1) ? $clog2(N_CAND) : 1
) (
  input  logic [N_CAND-1:0][2:0] key,
  output logic                   sel_any,
  output logic [IDX_W-1:0]       sel_idx
);
  import wgrow_pkg::*;

  logic [2:0] best;

  // walk from the top index down so equal keys settle on the lowest index
  always_comb begin
    best    = KEY_NONE;
    sel_idx = '0;
    for (int c = N_CAND - 1; c >= 0; c--) begin
      if (key[c] != KEY_NONE && key[c] <= best) begin
        best    = key[c];
        sel_idx = IDX_W'(c);
      end
    end
  end

  assign sel_any = (best != KEY_NONE);
endmodule

// File: rtl/win_grow_arbiter.sv
module win_grow_arbiter #(
  parameter int COORD_W  = 11,
  parameter int MAX_SIZE = 8,
  parameter int N_CAND   = 4,
  parameter int NEAR_MAX = 8,
  parameter int LAT      = 2,
  parameter int REGION_W = 585,
  parameter int REGION_H = 500,
  localparam int DIM_W   = $clog2(MAX_SIZE + 1),
  localparam int GRP     = (NEAR_MAX + LAT - 1) / LAT,
  localparam int IDX_W   = (N_CAND > 1) ? $clog2(N_CAND) : 1
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              ev_start,
  input  logic [COORD_W-1:0]                ev_x,
  input  logic [COORD_W-1:0]                ev_y,
  input  logic [N_CAND-1:0][2:0]            cand_dir,
  input  logic [N_CAND-1:0][COORD_W-1:0]    cand_x,
  input  logic [N_CAND-1:0][COORD_W-1:0]    cand_y,
  input  logic [N_CAND-1:0][DIM_W-1:0]      cand_w,
  input  logic [N_CAND-1:0][DIM_W-1:0]      cand_h,
  input  logic                              nb_beat,
  input  logic [GRP-1:0]                    nb_vld,
  input  logic [GRP-1:0][COORD_W-1:0]       nb_x,
  input  logic [GRP-1:0][COORD_W-1:0]       nb_y,
  input  logic [GRP-1:0][DIM_W-1:0]         nb_w,
  input  logic [GRP-1:0][DIM_W-1:0]         nb_h,
  output logic                              res_valid,
  output logic                              res_hit,
  output logic                              res_new,
  output logic [IDX_W-1:0]                  res_idx,
  output logic [COORD_W-1:0]                res_x,
  output logic [COORD_W-1:0]                res_y,
  output logic [DIM_W-1:0]                  res_w,
  output logic [DIM_W-1:0]                  res_h
);
  import wgrow_pkg::*;
  localparam int CNT_W = (LAT > 1) ? $clog2(LAT) : 1;

  // latched event
  logic                           busy;
  logic [CNT_W-1:0]               beat_cnt;
  logic [COORD_W-1:0]             evx_q, evy_q;
  logic [N_CAND-1:0][2:0]         cd_q;
  logic [N_CAND-1:0][COORD_W-1:0] cx_q, cy_q;
  logic [N_CAND-1:0][DIM_W-1:0]   cw_q, ch_q;
  logic [N_CAND-1:0][NDIR-1:0]    acc;

  // named internal events
  logic                           beat_take;
  logic                           last_beat;
  logic                           res_grew;
  logic [N_CAND-1:0][NDIR-1:0]    beat_ok;
  logic [N_CAND-1:0][NDIR-1:0]    fin_ok;
  logic [N_CAND-1:0][2:0]         key;
  logic [N_CAND-1:0][COORD_W-1:0] gx, gy;
  logic [N_CAND-1:0][DIM_W-1:0]   gw, gh;
  logic                           sel_any;
  logic [IDX_W-1:0]               sel_idx;

  assign beat_take = busy && nb_beat && !ev_start;
  assign last_beat = beat_take && (beat_cnt == CNT_W'(LAT - 1));

  for (genvar c = 0; c < N_CAND; c++) begin : g_cand
    logic [GRP-1:0][NDIR-1:0] slot_ok;

    for (genvar g = 0; g < GRP; g++) begin : g_slot
      wgrow_near_cmp #(.COORD_W(COORD_W), .DIM_W(DIM_W)) u_cmp (
        .cx(cx_q[c]), .cy(cy_q[c]), .cw(cw_q[c]), .ch(ch_q[c]),
        .nx(nb_x[g]), .ny(nb_y[g]), .nw(nb_w[g]), .nh(nb_h[g]),
        .ok(slot_ok[g])
      );
    end

    always_comb begin
      beat_ok[c] = '1;
      for (int g = 0; g < GRP; g++)
        if (nb_vld[g]) beat_ok[c] = beat_ok[c] & slot_ok[g];
    end

    assign fin_ok[c] = acc[c] & beat_ok[c];

    wgrow_cand_eval #(
      .COORD_W(COORD_W), .DIM_W(DIM_W), .MAX_SIZE(MAX_SIZE),
      .REGION_W(REGION_W), .REGION_H(REGION_H)
    ) u_eval (
      .dir(cd_q[c]), .x(cx_q[c]), .y(cy_q[c]), .w(cw_q[c]), .h(ch_q[c]),
      .near_ok(fin_ok[c]), .key(key[c]),
      .gx(gx[c]), .gy(gy[c]), .gw(gw[c]), .gh(gh[c])
    );
  end

  wgrow_pick #(.N_CAND(N_CAND)) u_pick (
    .key(key), .sel_any(sel_any), .sel_idx(sel_idx)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy      <= 1'b0;
      beat_cnt  <= '0;
      evx_q     <= '0;
      evy_q     <= '0;
      cd_q      <= '0;
      cx_q      <= '0;
      cy_q      <= '0;
      cw_q      <= '0;
      ch_q      <= '0;
      acc       <= '1;
      res_valid <= 1'b0;
      res_hit   <= 1'b0;
      res_new   <= 1'b0;
      res_grew  <= 1'b0;
      res_idx   <= '0;
      res_x     <= '0;
      res_y     <= '0;
      res_w     <= '0;
      res_h     <= '0;
    end else begin
      res_valid <= 1'b0;
      if (ev_start) begin
        busy     <= 1'b1;
        beat_cnt <= '0;
        acc      <= '1;
        evx_q    <= ev_x;
        evy_q    <= ev_y;
        cd_q     <= cand_dir;
        cx_q     <= cand_x;
        cy_q     <= cand_y;
        cw_q     <= cand_w;
        ch_q     <= cand_h;
      end else if (beat_take) begin
        acc      <= fin_ok;
        beat_cnt <= beat_cnt + CNT_W'(1);
        if (last_beat) begin
          busy      <= 1'b0;
          res_valid <= 1'b1;
          res_hit   <= sel_any;
          res_new   <= !sel_any;
          res_grew  <= sel_any && (key[sel_idx] != KEY_IN);
          res_idx   <= sel_any ? sel_idx : '0;
          res_x     <= sel_any ? gx[sel_idx] : evx_q;
          res_y     <= sel_any ? gy[sel_idx] : evy_q;
          res_w     <= sel_any ? gw[sel_idx] : DIM_W'(1);
          res_h     <= sel_any ? gh[sel_idx] : DIM_W'(1);
        end
      end
    end
  end

  a_r2_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |=> !res_valid);
  a_r2_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !ev_start) |=> !res_valid);
  a_r12_one_outcome: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> (res_hit != res_new));
  a_r12_unit_new: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && res_new) |-> (res_w == DIM_W'(1) && res_h == DIM_W'(1)));
  a_r9_size: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && res_grew) |-> (int'(res_w) <= MAX_SIZE && int'(res_h) <= MAX_SIZE));
  a_r10_bound: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && res_grew) |->
      (int'(res_x) + int'(res_w) <= REGION_W && int'(res_y) + int'(res_h) <= REGION_H));
  a_r8_acc_shrink: assert property (@(posedge clk) disable iff (!rst_n)
    beat_take |=> ((acc & ~$past(acc)) == '0));
endmodule

// File: tb/win_grow_arbiter_tb_top.sv
`timescale 1ns/1ps
module win_grow_arbiter_tb_top;
  localparam int CW = 11, DW = 4, NC = 4, LAT = 2, GRP = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic                     ev_start = 1'b0;
  logic [CW-1:0]            ev_x = '0, ev_y = '0;
  logic [NC-1:0][2:0]       cand_dir = '0;
  logic [NC-1:0][CW-1:0]    cand_x = '0, cand_y = '0;
  logic [NC-1:0][DW-1:0]    cand_w = '0, cand_h = '0;
  logic                     nb_beat = 1'b0;
  logic [GRP-1:0]           nb_vld = '0;
  logic [GRP-1:0][CW-1:0]   nb_x = '0, nb_y = '0;
  logic [GRP-1:0][DW-1:0]   nb_w = '0, nb_h = '0;
  logic                     res_valid, res_hit, res_new;
  logic [1:0]               res_idx;
  logic [CW-1:0]            res_x, res_y;
  logic [DW-1:0]            res_w, res_h;

  win_grow_arbiter dut_i (
    .clk(clk), .rst_n(rst_n), .ev_start(ev_start), .ev_x(ev_x), .ev_y(ev_y),
    .cand_dir(cand_dir), .cand_x(cand_x), .cand_y(cand_y), .cand_w(cand_w), .cand_h(cand_h),
    .nb_beat(nb_beat), .nb_vld(nb_vld), .nb_x(nb_x), .nb_y(nb_y), .nb_w(nb_w), .nb_h(nb_h),
    .res_valid(res_valid), .res_hit(res_hit), .res_new(res_new), .res_idx(res_idx),
    .res_x(res_x), .res_y(res_y), .res_w(res_w), .res_h(res_h)
  );

  // near windows per beat and slot, copied onto the ports beat by beat
  logic          bv [LAT][GRP];
  logic [CW-1:0] bx [LAT][GRP];
  logic [CW-1:0] by [LAT][GRP];
  logic [DW-1:0] bw [LAT][GRP];
  logic [DW-1:0] bh [LAT][GRP];
  bit early_hi;

  int ntot = 0, nbad = 0;
  bit finished = 1'b0;

  typedef struct packed {
    logic [4:0]    req;
    logic [2:0]    dir;
    logic [CW-1:0] evx, evy;
    logic [CW-1:0] cx, cy;
    logic [DW-1:0] cw, ch;
    logic          nv;
    logic [CW-1:0] nx, ny;
    logic [DW-1:0] nw, nh;
    logic          ehit;
    logic [CW-1:0] ex, ey;
    logic [DW-1:0] ew, eh;
  } vec_t;

  // candidate in slot 0, optional near window in beat 0 slot 1
  localparam vec_t VEC [20] = '{
    '{5'd4,  3'd2, 11'd103, 11'd50,  11'd100, 11'd50,  4'd3, 4'd2, 1'b0, 11'd0,   11'd0,  4'd1, 4'd1, 1'b1, 11'd100, 11'd50,  4'd4, 4'd2}, // R4 free
    '{5'd4,  3'd2, 11'd103, 11'd50,  11'd100, 11'd50,  4'd3, 4'd2, 1'b1, 11'd104, 11'd50, 4'd2, 4'd2, 1'b1, 11'd100, 11'd50,  4'd4, 4'd2}, // R4 gapR=1
    '{5'd4,  3'd2, 11'd103, 11'd50,  11'd100, 11'd50,  4'd3, 4'd2, 1'b1, 11'd103, 11'd51, 4'd1, 4'd1, 1'b0, 11'd103, 11'd50,  4'd1, 4'd1}, // R4 blocked
    '{5'd4,  3'd2, 11'd103, 11'd50,  11'd100, 11'd50,  4'd3, 4'd2, 1'b1, 11'd103, 11'd52, 4'd2, 4'd2, 1'b1, 11'd100, 11'd50,  4'd4, 4'd2}, // R4 gapD=0
    '{5'd5,  3'd3, 11'd103, 11'd52,  11'd100, 11'd50,  4'd3, 4'd2, 1'b1, 11'd103, 11'd53, 4'd2, 4'd1, 1'b1, 11'd100, 11'd50,  4'd4, 4'd3}, // R5 gapD=1
    '{5'd5,  3'd3, 11'd103, 11'd52,  11'd100, 11'd50,  4'd3, 4'd2, 1'b1, 11'd101, 11'd52, 4'd2, 4'd1, 1'b0, 11'd103, 11'd52,  4'd1, 4'd1}, // R5 blocked
    '{5'd6,  3'd4, 11'd101, 11'd52,  11'd100, 11'd50,  4'd3, 4'd2, 1'b1, 11'd103, 11'd52, 4'd1, 4'd1, 1'b1, 11'd100, 11'd50,  4'd3, 4'd3}, // R6 gapR=0
    '{5'd6,  3'd4, 11'd101, 11'd52,  11'd100, 11'd50,  4'd3, 4'd2, 1'b1, 11'd102, 11'd52, 4'd1, 4'd1, 1'b0, 11'd101, 11'd52,  4'd1, 4'd1}, // R6 blocked
    '{5'd7,  3'd5, 11'd99,  11'd52,  11'd100, 11'd50,  4'd3, 4'd2, 1'b1, 11'd98,  11'd52, 4'd1, 4'd1, 1'b1, 11'd99,  11'd50,  4'd4, 4'd3}, // R7 gapL=1
    '{5'd7,  3'd5, 11'd99,  11'd52,  11'd100, 11'd50,  4'd3, 4'd2, 1'b1, 11'd99,  11'd51, 4'd1, 4'd1, 1'b0, 11'd99,  11'd52,  4'd1, 4'd1}, // R7 gapL=0 blocked
    '{5'd9,  3'd2, 11'd108, 11'd50,  11'd100, 11'd50,  4'd8, 4'd2, 1'b0, 11'd0,   11'd0,  4'd1, 4'd1, 1'b0, 11'd108, 11'd50,  4'd1, 4'd1}, // R9 width full
    '{5'd9,  3'd4, 11'd101, 11'd58,  11'd100, 11'd50,  4'd3, 4'd8, 1'b0, 11'd0,   11'd0,  4'd1, 4'd1, 1'b0, 11'd101, 11'd58,  4'd1, 4'd1}, // R9 height full
    '{5'd9,  3'd2, 11'd107, 11'd50,  11'd100, 11'd50,  4'd7, 4'd2, 1'b0, 11'd0,   11'd0,  4'd1, 4'd1, 1'b1, 11'd100, 11'd50,  4'd8, 4'd2}, // R9 reaches 8
    '{5'd10, 3'd2, 11'd585, 11'd50,  11'd582, 11'd50,  4'd3, 4'd2, 1'b0, 11'd0,   11'd0,  4'd1, 4'd1, 1'b0, 11'd585, 11'd50,  4'd1, 4'd1}, // R10 right edge
    '{5'd10, 3'd4, 11'd101, 11'd500, 11'd100, 11'd497, 4'd3, 4'd3, 1'b0, 11'd0,   11'd0,  4'd1, 4'd1, 1'b0, 11'd101, 11'd500, 4'd1, 4'd1}, // R10 bottom edge
    '{5'd10, 3'd2, 11'd584, 11'd50,  11'd581, 11'd50,  4'd3, 4'd2, 1'b0, 11'd0,   11'd0,  4'd1, 4'd1, 1'b1, 11'd581, 11'd50,  4'd4, 4'd2}, // R10 last column
    '{5'd10, 3'd5, 11'd0,   11'd52,  11'd0,   11'd50,  4'd3, 4'd2, 1'b0, 11'd0,   11'd0,  4'd1, 4'd1, 1'b0, 11'd0,   11'd52,  4'd1, 4'd1}, // R10 left edge
    '{5'd3,  3'd1, 11'd101, 11'd51,  11'd100, 11'd50,  4'd3, 4'd2, 1'b1, 11'd103, 11'd51, 4'd1, 4'd1, 1'b1, 11'd100, 11'd50,  4'd3, 4'd2}, // R3 inside
    '{5'd13, 3'd0, 11'd101, 11'd51,  11'd100, 11'd50,  4'd3, 4'd2, 1'b0, 11'd0,   11'd0,  4'd1, 4'd1, 1'b0, 11'd101, 11'd51,  4'd1, 4'd1}, // R13 none
    '{5'd13, 3'd7, 11'd101, 11'd52,  11'd100, 11'd50,  4'd3, 4'd2, 1'b0, 11'd0,   11'd0,  4'd1, 4'd1, 1'b0, 11'd101, 11'd52,  4'd1, 4'd1}  // R13 code 7
  };

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    ntot++;
    if (!ok) begin
      nbad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic clear_all();
    cand_dir = '0;
    for (int c = 0; c < NC; c++) begin
      cand_x[c] = '0; cand_y[c] = '0; cand_w[c] = 4'd1; cand_h[c] = 4'd1;
    end
    for (int b = 0; b < LAT; b++)
      for (int g = 0; g < GRP; g++) begin
        bv[b][g] = 1'b0; bx[b][g] = '0; by[b][g] = '0; bw[b][g] = 4'd1; bh[b][g] = 4'd1;
      end
  endtask

  task automatic set_cand(input int c, input int d, input int x, input int y, input int w, input int h);
    cand_dir[c] = 3'(d); cand_x[c] = CW'(x); cand_y[c] = CW'(y);
    cand_w[c] = DW'(w); cand_h[c] = DW'(h);
  endtask

  task automatic set_near(input int b, input int g, input bit v, input int x, input int y, input int w, input int h);
    bv[b][g] = v; bx[b][g] = CW'(x); by[b][g] = CW'(y); bw[b][g] = DW'(w); bh[b][g] = DW'(h);
  endtask

  // start, then LAT beats; returns at the negedge where the result is visible
  task automatic fire(input int ex, input int ey);
    early_hi = 1'b0;
    @(negedge clk);
    ev_x = CW'(ex); ev_y = CW'(ey); ev_start = 1'b1;
    @(negedge clk);
    ev_start = 1'b0;
    for (int b = 0; b < LAT; b++) begin
      nb_beat = 1'b1;
      for (int g = 0; g < GRP; g++) begin
        nb_vld[g] = bv[b][g]; nb_x[g] = bx[b][g]; nb_y[g] = by[b][g];
        nb_w[g] = bw[b][g]; nb_h[g] = bh[b][g];
      end
      if (res_valid) early_hi = 1'b1;
      @(negedge clk);
    end
    nb_beat = 1'b0;
    nb_vld = '0;
  endtask

  task automatic expect_res(input string req, input bit hit, input int idx,
                            input int x, input int y, input int w, input int h);
    chk(res_valid === 1'b1, req, "res_valid", int'(res_valid), 1);
    chk(res_hit === hit && res_new === !hit, req, "res_hit", int'(res_hit), int'(hit));
    if (hit) chk(int'(res_idx) == idx, req, "res_idx", int'(res_idx), idx);
    chk(int'(res_x) == x && int'(res_y) == y, req, "res_x*4096+res_y",
        int'(res_x) * 4096 + int'(res_y), x * 4096 + y);
    chk(int'(res_w) == w && int'(res_h) == h, req, "res_w*16+res_h",
        int'(res_w) * 16 + int'(res_h), w * 16 + h);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      ntot++; nbad++;
      $display("FAIL R2 watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", ntot, nbad);
      $finish;
    end
  end

  initial begin
    clear_all();
    // R1: reset state
    repeat (3) @(negedge clk);
    chk(res_valid === 1'b0, "R1", "res_valid in reset", int'(res_valid), 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(res_valid === 1'b0, "R1", "res_valid idle", int'(res_valid), 0);

    // vector table
    for (int v = 0; v < 20; v++) begin
      clear_all();
      set_cand(0, int'(VEC[v].dir), int'(VEC[v].cx), int'(VEC[v].cy), int'(VEC[v].cw), int'(VEC[v].ch));
      set_near(0, 1, VEC[v].nv, int'(VEC[v].nx), int'(VEC[v].ny), int'(VEC[v].nw), int'(VEC[v].nh));
      fire(int'(VEC[v].evx), int'(VEC[v].evy));
      expect_res($sformatf("R%0d vec%0d", int'(VEC[v].req), v), VEC[v].ehit, 0,
                 int'(VEC[v].ex), int'(VEC[v].ey), int'(VEC[v].ew), int'(VEC[v].eh));
    end

    // R2: result timing and pulse width
    clear_all();
    set_cand(0, 2, 100, 50, 3, 2);
    fire(103, 50);
    chk(early_hi == 1'b0, "R2", "res_valid before last beat", int'(early_hi), 0);
    chk(res_valid === 1'b1, "R2", "res_valid after last beat", int'(res_valid), 1);
    @(negedge clk);
    chk(res_valid === 1'b0, "R2", "res_valid one cycle", int'(res_valid), 0);

    // R8: blocker only in the last slot of the second beat
    clear_all();
    set_cand(0, 2, 100, 50, 3, 2);
    set_near(0, 0, 1'b1, 104, 50, 2, 2);
    set_near(1, 3, 1'b1, 103, 51, 1, 1);
    fire(103, 50);
    expect_res("R8 late blocker", 1'b0, 0, 103, 50, 1, 1);

    // R8: blocker with its valid bit low has no effect
    clear_all();
    set_cand(0, 2, 100, 50, 3, 2);
    set_near(0, 0, 1'b0, 103, 51, 1, 1);
    set_near(1, 2, 1'b0, 103, 51, 1, 1);
    fire(103, 50);
    expect_res("R8 masked slot", 1'b1, 0, 100, 50, 4, 2);

    // R11: right beats down regardless of index
    clear_all();
    set_cand(0, 4, 100, 50, 3, 2);
    set_cand(1, 2, 200, 50, 2, 2);
    fire(202, 50);
    expect_res("R11 R over D", 1'b1, 1, 200, 50, 3, 2);

    // R11: right-down beats down
    clear_all();
    set_cand(2, 3, 300, 60, 2, 2);
    set_cand(3, 4, 400, 60, 2, 2);
    fire(302, 62);
    expect_res("R11 RD over D", 1'b1, 2, 300, 60, 3, 3);

    // R11: equal direction, lowest index wins
    clear_all();
    set_cand(1, 4, 100, 50, 3, 2);
    set_cand(3, 4, 200, 50, 3, 2);
    fire(101, 52);
    expect_res("R11 tie low index", 1'b1, 1, 100, 50, 3, 3);

    // R11 with R3: inside wins over a legal right growth
    clear_all();
    set_cand(0, 2, 100, 50, 3, 2);
    set_cand(3, 1, 200, 50, 3, 3);
    fire(201, 51);
    expect_res("R11 inside first", 1'b1, 3, 200, 50, 3, 3);

    // R11 with R8: blocked right candidate yields to left-down
    clear_all();
    set_cand(0, 2, 100, 50, 3, 2);
    set_cand(1, 5, 300, 60, 2, 2);
    set_near(1, 3, 1'b1, 103, 51, 1, 1);
    fire(299, 62);
    expect_res("R11 fallback LD", 1'b1, 1, 299, 60, 3, 3);

    // R12: all candidates blocked
    clear_all();
    set_cand(0, 2, 100, 50, 8, 2);
    set_cand(2, 4, 100, 40, 3, 8);
    fire(108, 50);
    expect_res("R12 new window", 1'b0, 0, 108, 50, 1, 1);

    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", ntot, nbad);
    $finish;
  end
endmodule